// File: doc/BRIEF.md
# Up-Counting Timer with One Compare Channel

This block is a timer that counts upward. Software controls it through a 32-bit register port, and it drives one level interrupt. A prescaler divides the module clock by a power of two to make the counting tick. A modulo register sets the value at which the count returns to zero. Each return to zero raises an overflow flag. A single channel compares the count against a programmed value while it is in software-compare mode, and records each match in an event flag. The event flag raises the interrupt when the channel's enable bit is set.

The counter width is a build parameter, 16 or 32 bits. Software can read it back from a read-only register. A write of any value to the count register restarts the count from zero. The event flag can be read, and cleared by writing one, in two places: the channel control register and a shared status register. Reads have no side effects. Read data is combinational and is zero whenever the read enable is low.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the count reads 0, the modulo register reads all ones across the counter width, the control, channel and status registers read 0, and `irq` is low.
- R2: The register at 0x04 reads the counter width in bits 23:16 (0x20 for 32 bits, 0x10 for 16 bits), with every other bit 0. Writes to it have no effect.
- R3: Bits 4:3 of the control register at 0x10 select the clock mode. Code 1 advances the count on every prescaled tick. Codes 0, 2 and 3 hold the count.
- R4: Bits 2:0 of the control register hold a code k. In clock mode 1 a tick occurs every 2^k module clocks. The divider phase starts from zero on a count write and advances only in clock mode 1.
- R5: When a tick occurs while the count (0x14) equals the modulo value (0x18), the count becomes 0 and bit 7 of the control register becomes 1. Writing 1 to that bit clears it, and a wrap in the same cycle wins over the clear.
- R6: Any write to the count register at 0x14 sets the count to 0, whatever the data. No tick takes effect in that cycle.
- R7: When bits 5:2 of the channel register at 0x20 hold 0x4, a tick that occurs while the count equals the compare value at 0x24 sets the event flag. The flag reads back in bit 7 of 0x20.
- R8: Bit 0 of the status register at 0x1C reads the event flag. Writing 1 to bit 0 of 0x1C or to bit 7 of 0x20 clears the flag, unless a compare match sets it in the same cycle.
- R9: `irq` is high exactly while the event flag and bit 6 of 0x20 are both 1.
- R10: When the mode field of 0x20 holds any value other than 0x4, no new event flag is set.
- R11: Unmapped addresses read 0, and `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one register per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt from the channel event |

## Verification
On every cycle the assertions check the following:
- a count write zeroes the count;
- a held clock mode freezes the count;
- a tick at the modulo value wraps the count and sets overflow;
- a status-register clear removes the flag when no match collides with it;
- `irq` never rises without the flag;
- a channel outside compare mode never raises a new flag.

Only the bench's scenarios can show that the counting rate follows each prescaler code. They also show that the compare match lands on the right count value, that both clear locations act on one shared flag, and that a lowered modulo produces repeated wraps. For this, a behavioural reference model runs beside the design and is compared with it on every clock.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam logic [ADDR_W-1:0] A_PARAM = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_MOD   = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_CHN   = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(8'h24);
  localparam logic [3:0]        SW_CMP  = 4'h4;

  logic [PS_W-1:0]  presc;
  logic [1:0]       cmode;
  logic             ovf;
  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] cnt, modv, cmpv;
  logic [3:0]       chmode;
  logic             chie, chf;

  logic wr_ctl, wr_cnt, wr_mod, wr_sts, wr_chn, wr_cmp;
  assign wr_ctl = wr_en && addr == A_CTL;
  assign wr_cnt = wr_en && addr == A_CNT;
  assign wr_mod = wr_en && addr == A_MOD;
  assign wr_sts = wr_en && addr == A_STS;
  assign wr_chn = wr_en && addr == A_CHN;
  assign wr_cmp = wr_en && addr == A_CMP;

  logic             run, tick, at_mod, hit, chf_clr;
  logic [DIV_W-1:0] div_mask;
  assign run      = cmode == 2'd1;
  assign div_mask = ~({DIV_W{1'b1}} << presc);
  assign tick     = run && ((div_cnt & div_mask) == div_mask) && !wr_cnt;
  assign at_mod   = cnt == modv;
  assign hit      = tick && chmode == SW_CMP && cnt == cmpv;
  assign chf_clr  = (wr_chn && wdata[7]) || (wr_sts && wdata[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc   <= '0;
      cmode   <= '0;
      ovf     <= 1'b0;
      div_cnt <= '0;
      cnt     <= '0;
      modv    <= '1;
      cmpv    <= '0;
      chmode  <= '0;
      chie    <= 1'b0;
      chf     <= 1'b0;
    end else begin
      if (wr_ctl) begin
        presc <= wdata[PS_W-1:0];
        cmode <= wdata[4:3];
      end
      if (wr_mod) modv <= wdata[CNT_W-1:0];
      if (wr_cmp) cmpv <= wdata[CNT_W-1:0];
      if (wr_chn) begin
        chmode <= wdata[5:2];
        chie   <= wdata[6];
      end

      if (wr_cnt)   div_cnt <= '0;
      else if (run) div_cnt <= div_cnt + 1'b1;

      if (wr_cnt)    cnt <= '0;
      else if (tick) cnt <= at_mod ? '0 : cnt + 1'b1;

      if (tick && at_mod)         ovf <= 1'b1;
      else if (wr_ctl && wdata[7]) ovf <= 1'b0;

      if (hit)          chf <= 1'b1;
      else if (chf_clr) chf <= 1'b0;
    end
  end

  assign irq = chf && chie;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_PARAM: rdata[23:16] = 8'(CNT_W);
        A_CTL:   rdata = {24'd0, ovf, 2'd0, cmode, 3'(presc)};
        A_CNT:   rdata = 32'(cnt);
        A_MOD:   rdata = 32'(modv);
        A_STS:   rdata = {31'd0, chf};
        A_CHN:   rdata = {24'd0, chf, chie, chmode, 2'd0};
        A_CMP:   rdata = 32'(cmpv);
        default: rdata = '0;
      endcase
    end
  end
endmodule

module cmp_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  modv,
  input logic [CNT_W-1:0]  cmpv,
  input logic [1:0]        cmode,
  input logic [3:0]        chmode,
  input logic              tick,
  input logic              ovf,
  input logic              chf
);
  // R6
  cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(8'h14) |=> cnt == '0);
  // R3
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmode != 2'd1 && !(wr_en && addr == ADDR_W'(8'h14)) |=> $stable(cnt));
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt == modv |=> cnt == '0 && ovf);
  // R8
  sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(8'h1C) && wdata[0]
      && !(tick && chmode == 4'h4 && cnt == cmpv) |=> !chf);
  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> chf);
  // R10
  no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chmode != 4'h4 && !chf |=> !chf);
  // R2
  param_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == ADDR_W'(8'h04) |-> rdata == (32'(CNT_W) << 16));
  // R11
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .irq(irq), .cnt(cnt), .modv(modv),
  .cmpv(cmpv), .cmode(cmode), .chmode(chmode), .tick(tick), .ovf(ovf),
  .chf(chf)
);

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
  localparam int CNT_W = 32;
  localparam int ADDR_W = 8;
  localparam longint MASK = (64'd1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cmp_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .irq(irq));

  // behavioural reference model
  longint m_cnt, m_mod, m_cmp;
  int m_ps, m_cm, m_ovf, m_div, m_mode, m_ie, m_chf;

  function automatic longint mread(int a);
    case (a)
      'h04: return longint'(CNT_W) << 16;
      'h10: return (m_ovf << 7) | (m_cm << 3) | m_ps;
      'h14: return m_cnt;
      'h18: return m_mod;
      'h1C: return m_chf;
      'h20: return (m_chf << 7) | (m_ie << 6) | (m_mode << 2);
      'h24: return m_cmp;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      'h04: return "R2";
      'h10: return "R5";
      'h14: return "R3";
      'h1C: return "R8";
      'h20: return "R7";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mod = MASK; m_cmp = 0; m_ps = 0; m_cm = 0; m_ovf = 0;
      m_div = 0; m_mode = 0; m_ie = 0; m_chf = 0;
    end else begin
      bit cw, tk, wrap, hit, clr;
      int a;
      a  = int'(addr);
      cw = wr_en && a == 'h14;
      tk = m_cm == 1 && (m_div % (1 << m_ps)) == (1 << m_ps) - 1 && !cw;
      wrap = tk && m_cnt == m_mod;
      hit  = tk && m_mode == 4 && m_cnt == m_cmp;
      clr  = wr_en && ((a == 'h20 && wdata[7]) || (a == 'h1C && wdata[0]));
      if (cw) m_div = 0; else if (m_cm == 1) m_div = (m_div + 1) % 128;
      if (cw) m_cnt = 0; else if (tk) m_cnt = wrap ? 0 : (m_cnt + 1) & MASK;
      if (wrap) m_ovf = 1; else if (wr_en && a == 'h10 && wdata[7]) m_ovf = 0;
      if (hit) m_chf = 1; else if (clr) m_chf = 0;
      if (wr_en && a == 'h10) begin m_ps = wdata[2:0]; m_cm = wdata[4:3]; end
      if (wr_en && a == 'h18) m_mod = longint'(wdata) & MASK;
      if (wr_en && a == 'h24) m_cmp = longint'(wdata) & MASK;
      if (wr_en && a == 'h20) begin m_mode = wdata[5:2]; m_ie = wdata[6]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      longint exp_rd;
      exp_rd = rd_en ? mread(int'(addr)) : 0;
      checks += 2;
      if (irq !== (m_chf && m_ie)) begin
        fails++;
        $display("FAIL R9 irq act=%0b exp=%0b", irq, m_chf && m_ie);
      end
      if (rdata !== 32'(exp_rd)) begin
        fails++;
        $display("FAIL %s rdata@%0h act=%0h exp=%0h",
                 rd_en ? req_of(int'(addr)) : "R11", addr, rdata, exp_rd);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1; rd_en = 0; addr = ADDR_W'(a); wdata = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(posedge clk); #2;
    rd_en = 1; wr_en = 0; addr = ADDR_W'(a);
    @(negedge clk); v = rdata;
    @(posedge clk); #2;
    rd_en = 0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    rd('h14, v); chk("R1 count", v, 0);
    rd('h18, v); chk("R1 modulo", v, 32'(MASK));
    rd('h10, v); chk("R1 ctrl", v, 0);
    rd('h20, v); chk("R1 chan", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 parameter register, read-only
    rd('h04, v); chk("R2 width", v, 32'h0020_0000);
    wr('h04, 32'hFFFF_FFFF);
    rd('h04, v); chk("R2 write ignored", v, 32'h0020_0000);

    // R11 unmapped
    rd('h08, v); chk("R11 unmapped", v, 0);

    // R3 stopped counter
    wr('h14, 0); repeat (10) @(posedge clk);
    rd('h14, v); chk("R3 held in mode 0", v, 0);
    wr('h10, 32'h10); repeat (20) @(posedge clk);
    rd('h14, v); chk("R3 held in mode 2", v, 0);

    // R7 compare in software mode, R9 irq
    wr('h24, 20);
    wr('h20, 32'h50);
    wr('h10, 32'h08);
    wr('h14, 0);
    @(posedge clk); #2; rd_en = 1; addr = 8'h14;
    wait_irq();
    chk("R7 count after match", rdata, 21);
    chk("R9 irq raised", 32'(irq), 1);
    wr('h10, 0);
    rd('h20, v); chk("R7 flag in chan", v, 32'hD0);
    rd('h1C, v); chk("R8 mirror", v, 1);
    wr('h1C, 1);
    rd('h20, v); chk("R8 clear via status", v, 32'h50);
    chk("R9 irq dropped", 32'(irq), 0);

    // R8 clear through channel register
    wr('h24, 3); wr('h14, 0); wr('h10, 32'h08);
    wait_irq();
    wr('h10, 0);
    wr('h20, 32'hD0);
    rd('h1C, v); chk("R8 clear via chan", v, 0);

    // R10 channel disabled
    wr('h20, 32'h40); wr('h14, 0); wr('h10, 32'h08);
    repeat (30) @(posedge clk);
    wr('h10, 0);
    rd('h1C, v); chk("R10 no flag", v, 0);
    chk("R10 irq low", 32'(irq), 0);

    // R5 modulo wrap and overflow flag
    wr('h18, 5); wr('h14, 0); wr('h10, 32'h08);
    repeat (20) @(posedge clk);
    wr('h10, 0);
    rd('h10, v); chk("R5 ovf set", v, 32'h80);
    wr('h10, 32'h80);
    rd('h10, v); chk("R5 ovf cleared", v, 0);

    // R4 prescaler codes, checked each cycle against the model
    wr('h18, 32'(MASK));
    wr('h10, 32'h0B); wr('h14, 0);
    repeat (90) @(posedge clk);
    wr('h10, 32'h09); repeat (20) @(posedge clk);
    wr('h10, 32'h0F); wr('h14, 0);
    repeat (300) @(posedge clk);
    rd('h14, v); chk("R4 div128 count", v, 32'(m_cnt));

    // R6 count write with nonzero data
    wr('h14, 32'h1234);
    rd('h14, v); chk("R6 count zeroed", v, 0);

    // R7 match with compare mode under prescale, collision handled by model
    wr('h20, 32'h50); wr('h24, 2); wr('h10, 32'h09); wr('h14, 0);
    wait_irq();
    chk("R7 irq with prescale", 32'(irq), 1);
    wr('h10, 0);

    repeat (5) @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule